// File: doc/BRIEF.md
# Accumulator CPU core with shared code and data memory

This block is a very small processor. It has an 8-bit accumulator, a carry flag and a 6-bit program counter. Code and data share one 64-word memory, which sits outside the block behind an asynchronous SRAM-style port. That port carries one bidirectional data bus, an address, an active-low read strobe and an active-low write strobe. Every instruction is one word long. Bits [7:6] hold the opcode and bits [5:0] hold either an operand address or a branch target. There are four operations:

- NOR with memory
- ADD memory into the accumulator, with carry out
- store the accumulator
- branch when carry is clear

The branch is the only control-transfer instruction. It also clears carry, so a second branch placed straight after it always jumps. Two branches in a row therefore give either an unconditional jump or a two-way decision.

A five-state machine sequences the work. The states are:

| State | Code | What it does |
|-------|------|--------------|
| FETCH | 000 | reads the instruction word |
| STORE | 001 | writes the accumulator to memory |
| ADD | 010 | reads the operand and adds it |
| NOR | 011 | reads the operand and NORs it |
| CLRC | 101 | clears carry after a branch that is not taken |

The transitions out of FETCH depend on the opcode and the carry:

| Condition in FETCH | Next state |
|--------------------|------------|
| opcode 00 | NOR |
| opcode 01 | ADD |
| opcode 10 | STORE |
| opcode 11, carry = 1 | CLRC |
| opcode 11, carry = 0 | FETCH (branch taken) |

Every other state goes unconditionally back to FETCH.

The next address never passes through the ALU. In FETCH the address register takes the low six bits of the word on the bus. The program counter takes the address register plus one. Each execute state then reloads the address register from the program counter.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low, the block does the following. `mem_addr` is 0 at once, without waiting for a clock edge. The state is FETCH, so `mem_oe_n` is 0 and `mem_we_n` is 1. The accumulator and carry are cleared. After release, the first instruction is fetched from address 0, and a store executed first writes 0.
- R2: An instruction word holds the opcode in bits [7:6] and the address or target in bits [5:0]. The opcodes are 00 NOR, 01 ADD, 10 STORE and 11 branch-if-carry-clear.
- R3: NOR sets the accumulator to the bitwise inverse of (accumulator OR mem[addr]). Carry is left unchanged.
- R4: ADD sets the accumulator to the low 8 bits of accumulator + mem[addr]. Carry takes the carry out of bit 7. A later branch shows the carry value.
- R5: STORE lasts exactly one cycle. In that cycle `mem_we_n` is 0, `mem_oe_n` is 1, `mem_addr` is the operand address and `mem_data` carries the accumulator.
- R6: A branch with carry 0 takes one cycle. In the cycle after the fetch, `mem_addr` shows the target and `mem_oe_n` is 0, because the target fetch is already under way.
- R7: A branch with carry 1 is not taken. It spends one CLRC cycle, in which both strobes are 1 and the bus floats. It clears carry, and the next fetch is at the following address. A branch placed straight after it is always taken.
- R8: NOR, ADD and STORE each take two cycles. The cycle after the fetch presents the operand address. The cycle after that fetches from the instruction address plus one.
- R9: `mem_oe_n` and `mem_we_n` are never both 0. The block drives `mem_data` only during STORE and leaves it high-impedance at all other times, including during reset.
- R10: `mem_oe_n` is 0 in FETCH, ADD and NOR, and 1 in STORE and CLRC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_data | inout | 8 | Shared data bus; instruction and operand reads, accumulator writes |
| mem_addr | output | 6 | Memory address, taken straight from the address register |
| mem_oe_n | output | 1 | Active-low memory read strobe |
| mem_we_n | output | 1 | Active-low memory write strobe |

## Verification
On every cycle, the assertions check the following:

- the two strobes are never active together, and a store lasts only one cycle;
- every execute state hands the program counter back as the next fetch address;
- a branch with carry clear lands on the target with no extra cycle;
- CLRC leaves carry at zero;
- the ADD and NOR results match the operands seen on the bus.

Only the bench's directed programs can show the rest. That covers the values that reach memory and cycle counts measured at the port. It also covers the behaviour seen when a branch follows another branch, and a complete greatest-common-divisor loop that uses all four operations together.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int unsigned OPC_W = 2;

    typedef enum logic [2:0] {
        ST_FETCH = 3'b000,
        ST_STORE = 3'b001,
        ST_ADD   = 3'b010,
        ST_NOR   = 3'b011,
        ST_CLRC  = 3'b101
    } cpu_state_e;

    typedef enum logic [OPC_W-1:0] {
        OP_NOR = 2'b00,
        OP_ADD = 2'b01,
        OP_STA = 2'b10,
        OP_JCC = 2'b11
    } opcode_e;

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  opcode_e    opcode,
    input  logic       carry,
    output cpu_state_e state,
    output logic       oe_n,
    output logic       we_n,
    output logic       drive_en,
    output logic       fetch_en,
    output logic       add_en,
    output logic       nor_en,
    output logic       clrc_en
);

    cpu_state_e state_q;
    cpu_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: only FETCH branches; everything else returns to FETCH
    always_comb begin
        state_d = ST_FETCH;
        unique case (state_q)
            ST_FETCH: begin
                unique case (opcode)
                    OP_NOR:  state_d = ST_NOR;
                    OP_ADD:  state_d = ST_ADD;
                    OP_STA:  state_d = ST_STORE;
                    OP_JCC:  state_d = carry ? ST_CLRC : ST_FETCH;
                    default: state_d = ST_FETCH;
                endcase
            end
            ST_STORE: state_d = ST_FETCH;
            ST_ADD:   state_d = ST_FETCH;
            ST_NOR:   state_d = ST_FETCH;
            ST_CLRC:  state_d = ST_FETCH;
            default:  state_d = ST_FETCH;
        endcase
    end

    // Outputs decoded from the registered state only
    always_comb begin
        oe_n     = 1'b1;
        we_n     = 1'b1;
        drive_en = 1'b0;
        fetch_en = 1'b0;
        add_en   = 1'b0;
        nor_en   = 1'b0;
        clrc_en  = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                oe_n     = 1'b0;
                fetch_en = 1'b1;
            end
            ST_STORE: begin
                we_n     = 1'b0;
                drive_en = 1'b1;
            end
            ST_ADD: begin
                oe_n   = 1'b0;
                add_en = 1'b1;
            end
            ST_NOR: begin
                oe_n   = 1'b0;
                nor_en = 1'b1;
            end
            ST_CLRC: begin
                clrc_en = 1'b1;
            end
            default: begin
                oe_n = 1'b1;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/acc_cpu_addr_path.sv
module acc_cpu_addr_path #(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_en,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] adreg,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] adreg_q;
    logic [ADDR_W-1:0] pc_q;

    // FETCH captures the operand/target and advances PC past the fetched word;
    // every other state returns the address register to the PC.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adreg_q <= '0;
            pc_q    <= '0;
        end else if (fetch_en) begin
            adreg_q <= bus_addr;
            pc_q    <= adreg_q + ADDR_ONE;
        end else begin
            adreg_q <= pc_q;
        end
    end

    assign adreg = adreg_q;
    assign pc    = pc_q;

endmodule

// File: rtl/acc_cpu_data_path.sv
module acc_cpu_data_path #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic              nor_en,
    input  logic              clrc_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] acc,
    output logic              carry
);

    // Carry lives in the top bit of one wide register
    logic [DATA_W:0] acc_c_q;
    logic [DATA_W:0] sum;

    assign sum = {1'b0, acc_c_q[DATA_W-1:0]} + {1'b0, bus_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_c_q <= '0;
        end else if (add_en) begin
            acc_c_q <= sum;
        end else if (nor_en) begin
            acc_c_q[DATA_W-1:0] <= ~(acc_c_q[DATA_W-1:0] | bus_in);
        end else if (clrc_en) begin
            acc_c_q[DATA_W] <= 1'b0;
        end
    end

    assign acc   = acc_c_q[DATA_W-1:0];
    assign carry = acc_c_q[DATA_W];

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    inout  wire  [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    localparam int unsigned OPC_LSB = DATA_W - OPC_W;

    cpu_state_e        state_q;
    logic              carry_q;
    logic [DATA_W-1:0] acc_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] adreg_q;
    logic              drive_en;
    logic              fetch_en;
    logic              add_en;
    logic              nor_en;
    logic              clrc_en;
    opcode_e           opcode;

    assign opcode = opcode_e'(mem_data[DATA_W-1:OPC_LSB]);

    acc_cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (opcode),
        .carry    (carry_q),
        .state    (state_q),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .drive_en (drive_en),
        .fetch_en (fetch_en),
        .add_en   (add_en),
        .nor_en   (nor_en),
        .clrc_en  (clrc_en)
    );

    acc_cpu_addr_path #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch_en (fetch_en),
        .bus_addr (mem_data[ADDR_W-1:0]),
        .adreg    (adreg_q),
        .pc       (pc_q)
    );

    acc_cpu_data_path #(.DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (add_en),
        .nor_en  (nor_en),
        .clrc_en (clrc_en),
        .bus_in  (mem_data),
        .acc     (acc_q),
        .carry   (carry_q)
    );

    assign mem_addr = adreg_q;
    assign mem_data = drive_en ? acc_q : {DATA_W{1'bz}};

endmodule

// File: rtl/acc_cpu_checker.sv
module acc_cpu_checker
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] mem_data,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input cpu_state_e        state,
    input logic              carry,
    input logic [DATA_W-1:0] acc,
    input logic [ADDR_W-1:0] pc
);

    // R1: reset holds address 0, fetch state, cleared accumulator and carry
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |-> (mem_addr == '0 && state == ST_FETCH && acc == '0 && !carry));

    // R9: strobes never active together
    a_r9_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R5: a write strobe lasts one cycle
    a_r5_store_single: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> mem_we_n);

    // R8: every execute state returns to fetch at the PC
    a_r8_return_to_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FETCH) |=> (state == ST_FETCH && mem_addr == $past(pc)));

    // R6: taken branch fetches its target next cycle
    a_r6_taken_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && mem_data[DATA_W-1:DATA_W-2] == 2'b11 && !carry)
        |=> (state == ST_FETCH && mem_addr == $past(mem_data[ADDR_W-1:0])));

    // R7: clear-carry state leaves carry at zero
    a_r7_clrc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLRC) |=> !carry);

    // R4: add result and carry out
    a_r4_add_result: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADD) |=>
        ({carry, acc} == ({1'b0, $past(acc)} + {1'b0, $past(mem_data)})));

    // R3: NOR result, carry untouched
    a_r3_nor_result: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NOR) |=>
        (acc == ~($past(acc) | $past(mem_data)) && carry == $past(carry)));

endmodule

bind acc_cpu_core acc_cpu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_data (mem_data),
    .mem_addr (mem_addr),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .state    (state_q),
    .carry    (carry_q),
    .acc      (acc_q),
    .pc       (pc_q)
);

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    wire  [7:0] mem_data;
    logic [5:0] mem_addr;
    logic       mem_oe_n;
    logic       mem_we_n;

    logic [7:0] mem [64];
    logic       mem_en = 1'b1;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    acc_cpu_core u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_data (mem_data),
        .mem_addr (mem_addr),
        .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n)
    );

    // Behavioural asynchronous memory
    assign mem_data = (mem_en && !mem_oe_n) ? mem[mem_addr] : 8'hzz;
    always @(posedge clk) begin
        if (!mem_we_n) mem[mem_addr] <= mem_data;
    end

    function automatic logic [7:0] ins(input logic [1:0] op, input logic [5:0] a);
        return {op, a};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    endtask

    task automatic reset_and_release();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R3 R8 R10: NOR results, operand cycle, two-cycle timing
    task automatic t_nor();
        clear_mem();
        mem[50] = 8'h5A; mem[51] = 8'h0F; mem[40] = 8'h77; mem[41] = 8'h77;
        mem[0] = ins(2'b00, 6'd50);
        mem[1] = ins(2'b10, 6'd40);
        mem[2] = ins(2'b00, 6'd51);
        mem[3] = ins(2'b10, 6'd41);
        mem[4] = ins(2'b11, 6'd4);
        mem[5] = ins(2'b11, 6'd4);
        reset_and_release();
        step();
        chk("R8 operand address", 16'(mem_addr), 16'd50);
        chk("R10 oe in NOR", 16'(mem_oe_n), 16'd0);
        step();
        chk("R8 next fetch address", 16'(mem_addr), 16'd1);
        repeat (20) step();
        chk("R3 NOR first", 16'(mem[40]), 16'hA5);
        chk("R3 NOR second", 16'(mem[41]), 16'h50);
    endtask

    // R1 R5 R6 R9: mid-run reset, taken branch in one cycle, store cycle
    task automatic t_reset_branch();
        clear_mem();
        mem[0] = ins(2'b00, 6'd62);
        mem[1] = ins(2'b11, 6'd1);
        reset_and_release();
        repeat (5) step();
        #(CLK_P/8);
        rst_n = 1'b0;
        mem_en = 1'b0;
        #1;
        chk("R1 async address", 16'(mem_addr), 16'd0);
        chk("R1 oe in reset", 16'(mem_oe_n), 16'd0);
        chk("R1 we in reset", 16'(mem_we_n), 16'd1);
        chk("R9 bus floats in reset", 16'(mem_data), 16'h00zz);
        mem_en = 1'b1;
        clear_mem();
        mem[40] = 8'h77;
        mem[0] = ins(2'b11, 6'd5);
        mem[5] = ins(2'b10, 6'd40);
        mem[6] = ins(2'b11, 6'd6);
        mem[7] = ins(2'b11, 6'd6);
        reset_and_release();
        step();
        chk("R6 taken target", 16'(mem_addr), 16'd5);
        chk("R6 fetch strobe", 16'(mem_oe_n), 16'd0);
        step();
        chk("R5 store address", 16'(mem_addr), 16'd40);
        chk("R5 we active", 16'(mem_we_n), 16'd0);
        chk("R5 oe idle", 16'(mem_oe_n), 16'd1);
        chk("R1 accumulator reset", 16'(mem_data), 16'h0000);
        step();
        chk("R5 store one cycle", 16'(mem_we_n), 16'd1);
        chk("R8 fetch after store", 16'(mem_addr), 16'd6);
        chk("R1 stored zero", 16'(mem[40]), 16'h0000);
    endtask

    // R4 R2: add with and without carry out, branch shows carry
    task automatic t_add();
        clear_mem();
        mem[50] = 8'h01; mem[51] = 8'h7F; mem[42] = 8'h55;
        mem[0] = ins(2'b00, 6'd62);
        mem[1] = ins(2'b01, 6'd50);
        mem[2] = ins(2'b10, 6'd40);
        mem[3] = ins(2'b01, 6'd51);
        mem[4] = ins(2'b10, 6'd41);
        mem[5] = ins(2'b11, 6'd8);
        mem[6] = ins(2'b00, 6'd62);
        mem[7] = ins(2'b10, 6'd42);
        mem[8] = ins(2'b11, 6'd8);
        mem[9] = ins(2'b11, 6'd8);
        reset_and_release();
        repeat (30) step();
        chk("R4 wrap sum", 16'(mem[40]), 16'h00);
        chk("R4 plain sum", 16'(mem[41]), 16'h7F);
        chk("R4 carry clear taken", 16'(mem[42]), 16'h55);
    endtask

    // R7 R10 R9: untaken branch, CLRC cycle, then second branch taken
    task automatic t_branch_pair();
        clear_mem();
        mem[60] = 8'hFF; mem[61] = 8'h01; mem[40] = 8'h77; mem[41] = 8'h77;
        mem[0]  = ins(2'b00, 6'd62);
        mem[1]  = ins(2'b01, 6'd61);
        mem[2]  = ins(2'b10, 6'd40);
        mem[3]  = ins(2'b11, 6'd20);
        mem[4]  = ins(2'b11, 6'd10);
        mem[10] = ins(2'b00, 6'd60);
        mem[11] = ins(2'b01, 6'd61);
        mem[12] = ins(2'b10, 6'd41);
        mem[13] = ins(2'b11, 6'd13);
        mem[14] = ins(2'b11, 6'd13);
        mem[20] = ins(2'b00, 6'd62);
        mem[21] = ins(2'b10, 6'd41);
        mem[22] = ins(2'b11, 6'd22);
        mem[23] = ins(2'b11, 6'd22);
        reset_and_release();
        repeat (7) step();
        chk("R7 CLRC oe idle", 16'(mem_oe_n), 16'd1);
        chk("R10 CLRC we idle", 16'(mem_we_n), 16'd1);
        chk("R9 bus floats in CLRC", 16'(mem_data), 16'h00zz);
        step();
        chk("R7 falls through", 16'(mem_addr), 16'd4);
        step();
        chk("R7 second branch taken", 16'(mem_addr), 16'd10);
        repeat (30) step();
        chk("R7 path marker", 16'(mem[41]), 16'h01);
        chk("R4 carry set sum", 16'(mem[40]), 16'h00);
    endtask

    // R2 R3 R4 R6 R7: greatest common divisor by repeated subtraction
    task automatic t_gcd(input logic [7:0] a, input logic [7:0] b, input logic [7:0] g);
        clear_mem();
        mem[60] = 8'hFF; mem[61] = 8'h01; mem[62] = 8'h00;
        mem[63] = a; mem[59] = b;
        mem[0]  = ins(2'b00, 6'd60);
        mem[1]  = ins(2'b00, 6'd59);
        mem[2]  = ins(2'b01, 6'd61);
        mem[3]  = ins(2'b01, 6'd63);
        mem[4]  = ins(2'b11, 6'd9);
        mem[5]  = ins(2'b10, 6'd63);
        mem[6]  = ins(2'b01, 6'd60);
        mem[7]  = ins(2'b11, 6'd13);
        mem[8]  = ins(2'b11, 6'd0);
        mem[9]  = ins(2'b00, 6'd62);
        mem[10] = ins(2'b01, 6'd61);
        mem[11] = ins(2'b10, 6'd59);
        mem[12] = ins(2'b11, 6'd0);
        mem[13] = ins(2'b11, 6'd13);
        mem[14] = ins(2'b11, 6'd13);
        reset_and_release();
        repeat (3000) step();
        chk("R7 gcd result", 16'(mem[59]), 16'(g));
        chk("R4 gcd a zero", 16'(mem[63]), 16'h00);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        t_nor();
        t_reset_branch();
        t_add();
        t_branch_pair();
        t_gcd(8'd36, 8'd24, 8'd12);
        t_gcd(8'd35, 8'd14, 8'd7);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule